// File: doc/BRIEF.md
# Signed-Digit Partial-Product Accumulation Tree

This block sums a set of signed-digit vectors into one signed-digit vector. It sits between partial-product generation and final conversion inside a wide multiplier. Each digit travels on two rails, an up rail and a down rail. The value of a digit is the up bit minus the down bit. The tree is built from two-operand signed-digit adders, and no carry inside an adder moves more than one digit position. The delay of every level therefore does not depend on the width, and each level halves the number of vectors.

The tree itself is purely combinational. A single register stage captures its result, so a sum appears one clock after its operands. When a level holds an odd number of vectors, the spare vector passes to the next level untouched. With the default eighteen inputs of 108 digits each, the tree has five adder levels.

Top module: `rb_acc_tree`

## Requirements
- R1: Input digit (up,down) encodings are (0,0)=0, (1,0)=+1 and (0,1)=−1. The pair (1,1) is accepted and reads as 0. Vector k occupies bits [k·DIGITS +: DIGITS] of each rail bus, and digit i has weight 2^i.
- R2: No output digit ever carries both rails high.
- R3: The output value (up vector minus down vector) equals the sum of all input values, modulo 2^DIGITS.
- R4: When every input digit in the top depth+1 positions is zero, the output value equals the exact signed sum of the inputs.
- R5: An input that reaches a level with no partner contributes its full value to the result.
- R6: The output is registered. It shows the sum of the operands present at the previous rising clock edge, and a synchronous active-low reset clears every output digit to (0,0).
- R7: All-zero inputs give an all-zero output on both rails.
- R8: Output digits below the lowest nonzero input position are always (0,0). Transfers only move toward more significant digits.
- R9: Inputs in which every digit is +1, or every digit is −1, below the guard positions sum correctly. These inputs maximise transfers at every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pp_pos | input | NUM_PP*DIGITS | Up rails of all input vectors |
| pp_neg | input | NUM_PP*DIGITS | Down rails of all input vectors |
| sum_pos | output | DIGITS | Up rail of the registered result |
| sum_neg | output | DIGITS | Down rail of the registered result |

## Verification
Inside one adder digit, two things can land in the same cycle: a transfer arriving from the digit below, and the intermediate digit that the digit's own operand pair has just produced. The choice rule must keep their sum inside {−1,0,+1}. The bench provokes this collision at every position by driving all-+1 and all-−1 vectors, together with dense random digits. It judges the result by comparing the integer value of the output with an independently computed sum, and by checking that no output digit shows both rails.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    // Number of vectors still present after l halving levels.
    function automatic int unsigned lvl_cnt(input int unsigned k, input int unsigned l);
        return (k + (32'd1 << l) - 1) >> l;
    endfunction

    // Levels needed to reduce k vectors to one.
    function automatic int unsigned tree_depth(input int unsigned k);
        int unsigned d;
        d = 0;
        while ((32'd1 << d) < k) d++;
        return d;
    endfunction

endpackage

// File: rtl/rb_vec_add.sv
module rb_vec_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_pos,
    input  logic [W-1:0] a_neg,
    input  logic [W-1:0] b_pos,
    input  logic [W-1:0] b_neg,
    output logic [W-1:0] z_pos,
    output logic [W-1:0] z_neg
);
    logic [W-1:0] a_up, a_dn, b_up, b_dn;
    logic [W-1:0] two_up, two_dn, one_up, one_dn;
    logic [W-1:0] calm;
    logic [W-1:0] w_up, w_dn;
    logic [W-2:0] t_up, t_dn;
    logic [W-1:0] tin_up, tin_dn;

    always_comb begin
        // (1,1) collapses to zero
        a_up = a_pos & ~a_neg;
        a_dn = a_neg & ~a_pos;
        b_up = b_pos & ~b_neg;
        b_dn = b_neg & ~b_pos;
        two_up = a_up & b_up;
        two_dn = a_dn & b_dn;
        one_up = (a_up ^ b_up) & ~(a_dn | b_dn);
        one_dn = (a_dn ^ b_dn) & ~(a_up | b_up);
        // lower operand pair holds no negative digit
        calm = {~(a_dn[W-2:0] | b_dn[W-2:0]), 1'b1};
        // intermediate digit: -1 when the incoming transfer is nonnegative
        w_up = (one_up | one_dn) & ~calm;
        w_dn = (one_up | one_dn) & calm;
        // outgoing transfer from digits 0..W-2; the top one leaves the word
        t_up = two_up[W-2:0] | (one_up[W-2:0] & calm[W-2:0]);
        t_dn = two_dn[W-2:0] | (one_dn[W-2:0] & ~calm[W-2:0]);
        tin_up = {t_up, 1'b0};
        tin_dn = {t_dn, 1'b0};
        z_pos = (w_up & ~tin_dn) | (tin_up & ~w_dn);
        z_neg = (w_dn & ~tin_up) | (tin_dn & ~w_up);
    end

endmodule

// File: rtl/rb_tree.sv
module rb_tree
    import rbt_pkg::*;
#(
    parameter int unsigned K = 18,
    parameter int unsigned W = 108
) (
    input  logic [K*W-1:0] pp_pos,
    input  logic [K*W-1:0] pp_neg,
    output logic [W-1:0]   sum_pos,
    output logic [W-1:0]   sum_neg
);
    localparam int unsigned LVLS = tree_depth(K);

    logic [W-1:0] lv_pos [0:LVLS][0:K-1];
    logic [W-1:0] lv_neg [0:LVLS][0:K-1];

    for (genvar j = 0; j < K; j++) begin : g_in
        assign lv_pos[0][j] = pp_pos[j*W +: W];
        assign lv_neg[0][j] = pp_neg[j*W +: W];
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar j = 0; j < K; j++) begin : g_slot
            if (j < lvl_cnt(K, l+1)) begin : g_used
                if (2*j+1 < lvl_cnt(K, l)) begin : g_add
                    rb_vec_add #(.W(W)) u_add (
                        .a_pos(lv_pos[l][2*j]),   .a_neg(lv_neg[l][2*j]),
                        .b_pos(lv_pos[l][2*j+1]), .b_neg(lv_neg[l][2*j+1]),
                        .z_pos(lv_pos[l+1][j]),   .z_neg(lv_neg[l+1][j])
                    );
                end else begin : g_pass
                    // R5: spare vector moves up unchanged
                    assign lv_pos[l+1][j] = lv_pos[l][2*j];
                    assign lv_neg[l+1][j] = lv_neg[l][2*j];
                end
            end else begin : g_idle
                assign lv_pos[l+1][j] = '0;
                assign lv_neg[l+1][j] = '0;
            end
        end
    end

    assign sum_pos = lv_pos[LVLS][0];
    assign sum_neg = lv_neg[LVLS][0];

endmodule

// File: rtl/rb_acc_tree.sv
module rb_acc_tree #(
    parameter int unsigned NUM_PP = 18,
    parameter int unsigned DIGITS = 108
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PP*DIGITS-1:0] pp_pos,
    input  logic [NUM_PP*DIGITS-1:0] pp_neg,
    output logic [DIGITS-1:0]        sum_pos,
    output logic [DIGITS-1:0]        sum_neg
);
    typedef struct packed {
        logic [DIGITS-1:0] pos;
        logic [DIGITS-1:0] neg;
    } acc_t;

    acc_t st_d, st_q;
    logic [DIGITS-1:0] tree_pos, tree_neg;

    rb_tree #(.K(NUM_PP), .W(DIGITS)) u_tree (
        .pp_pos (pp_pos),
        .pp_neg (pp_neg),
        .sum_pos(tree_pos),
        .sum_neg(tree_neg)
    );

    always_comb begin
        st_d.pos = tree_pos;
        st_d.neg = tree_neg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_pos = st_q.pos;
    assign sum_neg = st_q.neg;

    // Plain modular sum of the inputs, used only by the checks below
    logic [DIGITS-1:0] ref_val;
    always_comb begin
        ref_val = '0;
        for (int k = 0; k < NUM_PP; k++)
            ref_val = ref_val + pp_pos[k*DIGITS +: DIGITS] - pp_neg[k*DIGITS +: DIGITS];
    end

    // R2
    no_both_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_pos & sum_neg) == '0);

    // R3
    value_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sum_pos - sum_neg) == $past(ref_val));

    // R7
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_pos == '0 && pp_neg == '0) |=> (sum_pos == '0 && sum_neg == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pp_pos) && $stable(pp_neg) && $past(rst_n))
        |=> ($stable(sum_pos) && $stable(sum_neg)));

endmodule

// File: tb/test_rb_acc_tree.sv
module test_rb_acc_tree;
    localparam int unsigned K = 18;
    localparam int unsigned W = 108;
    localparam int unsigned VW = W + 8;
    localparam int unsigned GUARD = 8;
    localparam int unsigned LOWZ = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K*W-1:0] pp_pos = '0;
    logic [K*W-1:0] pp_neg = '0;
    logic [W-1:0] sum_pos, sum_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rb_acc_tree #(.NUM_PP(K), .DIGITS(W)) i_rb_acc_tree (
        .clk(clk), .rst_n(rst_n), .pp_pos(pp_pos), .pp_neg(pp_neg),
        .sum_pos(sum_pos), .sum_neg(sum_neg)
    );

    // mode, seed
    localparam logic [35:0] TBL [12] = '{
        {4'd0, 32'h1234_5678}, {4'd0, 32'h9abc_def1},
        {4'd1, 32'h0bad_cafe}, {4'd1, 32'h7777_1111},
        {4'd2, 32'h0000_0001}, {4'd3, 32'h0000_0002},
        {4'd4, 32'h4242_4242}, {4'd4, 32'h1357_9bdf},
        {4'd5, 32'h2468_ace0}, {4'd5, 32'h5555_aaaa},
        {4'd6, 32'h0f0f_0f0f}, {4'd1, 32'hdead_beef}
    };

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic signed [VW-1:0] rails_val(input logic [W-1:0] p, input logic [W-1:0] n);
        logic signed [VW-1:0] a, b;
        a = {{(VW-W){1'b0}}, p};
        b = {{(VW-W){1'b0}}, n};
        return a - b;
    endfunction

    task automatic check(input bit ok, input string req, input logic signed [VW-1:0] act,
                         input logic signed [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input logic [3:0] mode, input logic [31:0] seed,
                         output logic signed [VW-1:0] expv);
        logic [31:0] r;
        logic p, n;
        r = seed;
        expv = '0;
        for (int k = 0; k < K; k++) begin
            for (int i = 0; i < W; i++) begin
                r = xs(r);
                p = r[0];
                n = r[1];
                case (mode)
                    4'd0: ;
                    4'd1: if (i >= W-GUARD) begin p = 0; n = 0; end
                    4'd2: begin p = (i < W-GUARD); n = 0; end
                    4'd3: begin p = 0; n = (i < W-GUARD); end
                    4'd4: if (k != K-1 || i >= W-GUARD) begin p = 0; n = 0; end
                    4'd5: if (i < LOWZ || i >= W-GUARD) begin p = 0; n = 0; end
                    default: begin p = (i < W-GUARD); n = p; end
                endcase
                pp_pos[k*W+i] = p;
                pp_neg[k*W+i] = n;
            end
            expv = expv + rails_val(pp_pos[k*W +: W], pp_neg[k*W +: W]);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic signed [VW-1:0] expv, outv, prev;
        logic [3:0] mode;
        // R6: reset clears output even with nonzero inputs
        build(4'd0, 32'hcafe_f00d, expv);
        repeat (3) @(posedge clk);
        #1;
        check(sum_pos == '0 && sum_neg == '0, "R6 reset",
              rails_val(sum_pos, sum_neg), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: zero inputs
        @(negedge clk);
        pp_pos = '0; pp_neg = '0;
        @(posedge clk); #1;
        check(sum_pos == '0 && sum_neg == '0, "R7 zero", rails_val(sum_pos, sum_neg), 0);

        foreach (TBL[t]) begin
            mode = TBL[t][35:32];
            @(negedge clk);
            build(mode, TBL[t][31:0], expv);
            @(posedge clk); #1;
            outv = rails_val(sum_pos, sum_neg);
            check((sum_pos & sum_neg) == '0, "R2 rails", outv, expv);
            check(outv[W-1:0] == expv[W-1:0], "R3 modular", outv, expv);
            if (mode != 4'd0)
                check(outv == expv, "R4 exact", outv, expv);
            if (mode == 4'd2 || mode == 4'd3)
                check(outv == expv, "R9 dense", outv, expv);
            if (mode == 4'd4)
                check(outv == expv, "R5 spare", outv, expv);
            if (mode == 4'd5)
                check(sum_pos[LOWZ-1:0] == '0 && sum_neg[LOWZ-1:0] == '0, "R8 low",
                      outv, expv);
            if (mode == 4'd6)
                check(outv == 0, "R1 both", outv, 0);
        end

        // R6: one-cycle latency, output holds until the next edge
        prev = rails_val(sum_pos, sum_neg);
        @(negedge clk);
        build(4'd1, 32'h3141_5926, expv);
        #1;
        check(rails_val(sum_pos, sum_neg) == prev, "R6 hold", rails_val(sum_pos, sum_neg), prev);
        @(posedge clk); #1;
        check(rails_val(sum_pos, sum_neg) == expv, "R6 latency",
              rails_val(sum_pos, sum_neg), expv);

        // R1: single +1 and -1 digits at known positions
        @(negedge clk);
        pp_pos = '0; pp_neg = '0;
        pp_pos[0*W + 3] = 1'b1;
        pp_neg[5*W + 0] = 1'b1;
        pp_pos[9*W + 7] = 1'b1; pp_neg[9*W + 7] = 1'b1;
        @(posedge clk); #1;
        check(rails_val(sum_pos, sum_neg) == 7, "R1 encoding", rails_val(sum_pos, sum_neg), 7);

        // R6: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(sum_pos == '0 && sum_neg == '0, "R6 reset again", rails_val(sum_pos, sum_neg), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule